// File: doc/BRIEF.md
# Kd-Tree Nearest-Neighbour Traversal Controller

This block steers a single nearest-neighbour search through a kd-tree kept in on-chip tables. Given a three-axis signed fixed-point query, it walks from the root toward the leaf cell holding the query. At every split it parks the branch it did not take, along with the squared query-to-plane distance, on an explicit hardware stack. On reaching a leaf it asks a downstream point engine to process that leaf's bucket of points. It then waits for the engine to report back the current worst neighbour distance.

Backtracking replaces recursion. Stack entries are popped one at a time. A parked branch is entered only when the reported worst distance still exceeds that branch's plane distance; otherwise the entry is thrown away. The search ends when a leaf finishes and no entries remain. Tree contents are written through two plain write ports before a search starts.

Top module: `kd_trav_top`

## Requirements
- R1: After reset, `busy`, `leafReqValid`, `searchDone` and `stackErr` are all 0.
- R2: Nodes are heap-indexed with the root at index 1 and the children of node i at 2i (left) and 2i+1 (right). A pointer is a leaf when its index is at least 2^TREE_DEPTH or when its node carries the leaf flag. A leaf's begin and end pointers are read from the leaf table at that same index.
- R3: At an internal node the split axis is 0 for x, 1 for y, and 2 or 3 for z. The signed difference is the query coordinate minus the split value. A difference above zero descends left first; zero or below descends right first.
- R4: Each descent pushes the untaken child together with the square of the difference from R3.
- R5: At a leaf, `leafReqValid` rises with that leaf's `leafBegin`/`leafEnd`. All three hold steady until `leafReqReady` is seen high.
- R6: After the request is accepted, traversal stalls until a `leafDone` pulse arrives. The `leafWorst` value sampled with that pulse becomes the worst distance.
- R7: On a pop, the popped branch is descended only if the worst distance is strictly greater than its stored squared distance. Otherwise the entry is discarded and the next entry is popped.
- R8: When a leaf has finished and the stack is empty, `searchDone` pulses for exactly one cycle and `busy` drops in that same cycle.
- R9: A push onto a full stack drops the entry and sets `stackErr`. The flag stays set until reset, and the search still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeWe | input | 1 | Node table write strobe |
| nodeAddr | input | TREE_DEPTH | Node heap index to write |
| nodeSplitIn | input | COORD_W | Signed split value |
| nodeDimIn | input | 2 | Split axis |
| nodeLeafIn | input | 1 | Node is a leaf |
| leafWe | input | 1 | Leaf table write strobe |
| leafAddr | input | TREE_DEPTH+1 | Leaf heap index to write |
| leafBeginIn | input | PTR_W | Bucket begin pointer |
| leafEndIn | input | PTR_W | Bucket end pointer |
| start | input | 1 | Start a search (ignored while busy) |
| queryX | input | COORD_W | Query x, signed |
| queryY | input | COORD_W | Query y, signed |
| queryZ | input | COORD_W | Query z, signed |
| leafReqValid | output | 1 | Leaf bucket request valid |
| leafReqReady | input | 1 | Leaf request accepted |
| leafBegin | output | PTR_W | Requested bucket begin |
| leafEnd | output | PTR_W | Requested bucket end |
| leafDone | input | 1 | Leaf handled, worst distance valid |
| leafWorst | input | 2*COORD_W+2 | Current worst squared neighbour distance |
| busy | output | 1 | Search in progress |
| searchDone | output | 1 | One-cycle end-of-search pulse |
| stackErr | output | 1 | Sticky stack overflow flag |

## Verification
The hardest cases to reach from the ports are the accept/reject decisions during backtracking. These decisions are made on stored plane distances that never appear outside the block. The bench therefore builds a small unbalanced tree and uses a behavioural model of the rules to predict the full ordered list of leaf buckets for each query and returned worst distance. It chooses worst values equal to, just above and far above specific plane distances, so that every leaf visited exposes one pop decision. Overflow cannot occur with a stack deep enough for the tree. A second instance with a two-entry stack is therefore driven along a three-level path.

// File: rtl/kd_trav_pkg.sv
package kd_trav_pkg;
  typedef struct packed {
    logic loadRoot;
    logic descend;
    logic pop;
    logic loadWorst;
  } travStrobe_t;

  typedef struct packed {
    logic isLeaf;
    logic stackEmpty;
    logic popAccept;
  } travStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_REQ, ST_WAIT, ST_POP
  } travState_t;
endpackage

// File: rtl/kd_trav_dp.sv
module kd_trav_dp
  import kd_trav_pkg::*;
#(
  parameter int COORD_W     = 32,
  parameter int PTR_W       = 25,
  parameter int TREE_DEPTH  = 8,
  parameter int STACK_DEPTH = 16,
  localparam int NPTR_W = TREE_DEPTH + 1,
  localparam int DIST_W = 2 * COORD_W + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      nodeWe,
  input  logic [TREE_DEPTH-1:0]     nodeAddr,
  input  logic [COORD_W-1:0]        nodeSplitIn,
  input  logic [1:0]                nodeDimIn,
  input  logic                      nodeLeafIn,
  input  logic                      leafWe,
  input  logic [NPTR_W-1:0]         leafAddr,
  input  logic [PTR_W-1:0]          leafBeginIn,
  input  logic [PTR_W-1:0]          leafEndIn,
  input  logic [COORD_W-1:0]        queryX,
  input  logic [COORD_W-1:0]        queryY,
  input  logic [COORD_W-1:0]        queryZ,
  input  logic [DIST_W-1:0]         leafWorst,
  input  travStrobe_t               str,
  output travStatus_t               status,
  output logic [PTR_W-1:0]          leafBegin,
  output logic [PTR_W-1:0]          leafEnd,
  output logic                      stackErr
);
  localparam int NODES = 1 << TREE_DEPTH;
  localparam int LEAVES = 1 << NPTR_W;
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int SI_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [COORD_W-1:0] nodeSplitM [NODES];
  logic [1:0]         nodeDimM   [NODES];
  logic               nodeLeafM  [NODES];
  logic [PTR_W-1:0]   leafBegM   [LEAVES];
  logic [PTR_W-1:0]   leafEndM   [LEAVES];

  logic [NPTR_W-1:0]  stkPtr  [STACK_DEPTH];
  logic [DIST_W-1:0]  stkDist [STACK_DEPTH];

  logic [COORD_W-1:0] qCoord [3];
  logic [NPTR_W-1:0]  curPtr;
  logic [SP_W-1:0]    sp;
  logic [DIST_W-1:0]  worst;

  logic [TREE_DEPTH-1:0] nodeIdx;
  logic [COORD_W-1:0]    selCoord;
  logic [COORD_W-1:0]    splitVal;
  logic [COORD_W:0]      diff;
  logic [COORD_W:0]      absDiff;
  logic [DIST_W-1:0]     planeSq;
  logic                  goLeft;
  logic [NPTR_W-1:0]     nearChild;
  logic [NPTR_W-1:0]     farChild;
  logic [SI_W-1:0]       topIdx;
  logic [SI_W-1:0]       pushIdx;
  logic                  stackFull;

  always_ff @(posedge clk) begin
    if (nodeWe) begin
      nodeSplitM[nodeAddr] <= nodeSplitIn;
      nodeDimM[nodeAddr]   <= nodeDimIn;
      nodeLeafM[nodeAddr]  <= nodeLeafIn;
    end
    if (leafWe) begin
      leafBegM[leafAddr] <= leafBeginIn;
      leafEndM[leafAddr] <= leafEndIn;
    end
  end

  always_comb begin
    nodeIdx  = curPtr[TREE_DEPTH-1:0];
    splitVal = nodeSplitM[nodeIdx];
    case (nodeDimM[nodeIdx])
      2'd0:    selCoord = qCoord[0];
      2'd1:    selCoord = qCoord[1];
      default: selCoord = qCoord[2];
    endcase
    diff      = {selCoord[COORD_W-1], selCoord} - {splitVal[COORD_W-1], splitVal};
    absDiff   = diff[COORD_W] ? (~diff + 1'b1) : diff;
    planeSq   = {{(COORD_W + 1){1'b0}}, absDiff} * {{(COORD_W + 1){1'b0}}, absDiff};
    goLeft    = !diff[COORD_W] && (diff != '0);
    nearChild = {nodeIdx, ~goLeft};
    farChild  = {nodeIdx, goLeft};
    topIdx    = SI_W'(sp - 1'b1);
    pushIdx   = SI_W'(sp);
    stackFull = (sp == SP_W'(STACK_DEPTH));
  end

  assign status.isLeaf     = curPtr[TREE_DEPTH] | nodeLeafM[nodeIdx];
  assign status.stackEmpty = (sp == '0);
  assign status.popAccept  = (sp != '0) && (worst > stkDist[topIdx]);
  assign leafBegin = leafBegM[curPtr];
  assign leafEnd   = leafEndM[curPtr];

  always_ff @(posedge clk) begin
    if (str.descend && !stackFull) begin
      stkPtr[pushIdx]  <= farChild;
      stkDist[pushIdx] <= planeSq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCoord[0] <= '0;
      qCoord[1] <= '0;
      qCoord[2] <= '0;
      curPtr    <= '0;
      sp        <= '0;
      worst     <= '0;
      stackErr  <= 1'b0;
    end else begin
      if (str.loadRoot) begin
        qCoord[0] <= queryX;
        qCoord[1] <= queryY;
        qCoord[2] <= queryZ;
        curPtr    <= NPTR_W'(1);
        sp        <= '0;
      end
      if (str.descend) begin
        curPtr <= nearChild;
        if (stackFull) stackErr <= 1'b1;
        else           sp <= sp + 1'b1;
      end
      if (str.pop) begin
        sp <= sp - 1'b1;
        if (status.popAccept) curPtr <= stkPtr[topIdx];
      end
      if (str.loadWorst) worst <= leafWorst;
    end
  end

  // R9: depth never exceeds capacity, flag never clears
  p_sp_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);
  // R7: every pop removes exactly one entry
  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (str.pop && !str.loadRoot) |=> sp == $past(sp) - 1'b1);
  // R2: a search begins at the root
  p_root_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.loadRoot |=> curPtr == NPTR_W'(1));
endmodule

// File: rtl/kd_trav_ctrl.sv
module kd_trav_ctrl
  import kd_trav_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        leafReqReady,
  input  logic        leafDone,
  input  travStatus_t status,
  output travStrobe_t str,
  output logic        leafReqValid,
  output logic        busy,
  output logic        searchDone
);
  travState_t state, stateNext;

  always_comb begin
    stateNext = state;
    str       = '0;
    case (state)
      ST_IDLE: if (start) begin
        str.loadRoot = 1'b1;
        stateNext    = ST_DESC;
      end
      ST_DESC: begin
        if (status.isLeaf) stateNext = ST_REQ;
        else               str.descend = 1'b1;
      end
      ST_REQ:  if (leafReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (leafDone) begin
        str.loadWorst = 1'b1;
        stateNext     = ST_POP;
      end
      ST_POP: begin
        if (status.stackEmpty) stateNext = ST_IDLE;
        else begin
          str.pop = 1'b1;
          if (status.popAccept) stateNext = ST_DESC;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      searchDone <= 1'b0;
    end else begin
      state      <= stateNext;
      searchDone <= (state == ST_POP) && status.stackEmpty;
    end
  end

  assign leafReqValid = (state == ST_REQ);
  assign busy         = (state != ST_IDLE);

  // R8: completion is a single-cycle pulse that coincides with idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    searchDone |=> !searchDone);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    searchDone |-> !busy);
  // R6: while waiting for a leaf, no further request is raised
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !leafDone) |=> !leafReqValid);
endmodule

// File: rtl/kd_trav_top.sv
module kd_trav_top
  import kd_trav_pkg::*;
#(
  parameter int COORD_W     = 32,
  parameter int PTR_W       = 25,
  parameter int TREE_DEPTH  = 8,
  parameter int STACK_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    nodeWe,
  input  logic [TREE_DEPTH-1:0]   nodeAddr,
  input  logic [COORD_W-1:0]      nodeSplitIn,
  input  logic [1:0]              nodeDimIn,
  input  logic                    nodeLeafIn,
  input  logic                    leafWe,
  input  logic [TREE_DEPTH:0]     leafAddr,
  input  logic [PTR_W-1:0]        leafBeginIn,
  input  logic [PTR_W-1:0]        leafEndIn,
  input  logic                    start,
  input  logic [COORD_W-1:0]      queryX,
  input  logic [COORD_W-1:0]      queryY,
  input  logic [COORD_W-1:0]      queryZ,
  output logic                    leafReqValid,
  input  logic                    leafReqReady,
  output logic [PTR_W-1:0]        leafBegin,
  output logic [PTR_W-1:0]        leafEnd,
  input  logic                    leafDone,
  input  logic [2*COORD_W+1:0]    leafWorst,
  output logic                    busy,
  output logic                    searchDone,
  output logic                    stackErr
);
  travStrobe_t str;
  travStatus_t status;

  kd_trav_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .leafReqReady(leafReqReady),
    .leafDone(leafDone), .status(status), .str(str),
    .leafReqValid(leafReqValid), .busy(busy), .searchDone(searchDone)
  );

  kd_trav_dp #(
    .COORD_W(COORD_W), .PTR_W(PTR_W), .TREE_DEPTH(TREE_DEPTH), .STACK_DEPTH(STACK_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .nodeWe(nodeWe), .nodeAddr(nodeAddr),
    .nodeSplitIn(nodeSplitIn), .nodeDimIn(nodeDimIn), .nodeLeafIn(nodeLeafIn),
    .leafWe(leafWe), .leafAddr(leafAddr), .leafBeginIn(leafBeginIn), .leafEndIn(leafEndIn),
    .queryX(queryX), .queryY(queryY), .queryZ(queryZ), .leafWorst(leafWorst),
    .str(str), .status(status), .leafBegin(leafBegin), .leafEnd(leafEnd),
    .stackErr(stackErr)
  );

  // R5: a pending request holds its payload until taken
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (leafReqValid && !leafReqReady) |=>
      (leafReqValid && $stable(leafBegin) && $stable(leafEnd)));
endmodule

// File: tb/tb_kd_trav_top.sv
module tb_kd_trav_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 25;
  localparam int TD = 3;
  localparam int DW = 2 * CW + 2;
  localparam int NV = 6;

  localparam int VX [NV] = '{3, 3, 0, -4, 5, -30};
  localparam int VY [NV] = '{2, 2, 0, 0, 20, 100};
  localparam int VZ [NV] = '{0, 0, 0, 0, -9, 7};
  localparam longint VW [NV] = '{64, 65, 0, 17, 64'h3_FFFF_FFFF, 0};

  logic clk = 0, rstN = 0;
  logic nodeWe = 0, nodeLeafIn = 0, leafWe = 0;
  logic [TD-1:0] nodeAddr = '0;
  logic [CW-1:0] nodeSplitIn = '0;
  logic [1:0] nodeDimIn = '0;
  logic [TD:0] leafAddr = '0;
  logic [PW-1:0] leafBeginIn = '0, leafEndIn = '0;
  logic start = 0, ovfStart = 0;
  logic [CW-1:0] qX = '0, qY = '0, qZ = '0;
  logic leafReqValid, leafReqReady = 0, leafDone = 0;
  logic [PW-1:0] leafBegin, leafEnd;
  logic [DW-1:0] leafWorst = '0;
  logic busy, searchDone, stackErr;
  logic oValid, oDone, oBusy, oErr, ovfLeafDone = 0;
  logic [PW-1:0] oBeg, oEnd;

  int checks = 0, fails = 0;
  int tSplit [8], tDim [8], tLeaf [8];
  int expSeq [16];
  int expN;

  always #(CLK_PERIOD / 2) clk = ~clk;

  kd_trav_top #(.COORD_W(CW), .PTR_W(PW), .TREE_DEPTH(TD), .STACK_DEPTH(3)) dut (
    .clk(clk), .rstN(rstN), .nodeWe(nodeWe), .nodeAddr(nodeAddr), .nodeSplitIn(nodeSplitIn),
    .nodeDimIn(nodeDimIn), .nodeLeafIn(nodeLeafIn), .leafWe(leafWe), .leafAddr(leafAddr),
    .leafBeginIn(leafBeginIn), .leafEndIn(leafEndIn), .start(start), .queryX(qX),
    .queryY(qY), .queryZ(qZ), .leafReqValid(leafReqValid), .leafReqReady(leafReqReady),
    .leafBegin(leafBegin), .leafEnd(leafEnd), .leafDone(leafDone), .leafWorst(leafWorst),
    .busy(busy), .searchDone(searchDone), .stackErr(stackErr));

  kd_trav_top #(.COORD_W(CW), .PTR_W(PW), .TREE_DEPTH(TD), .STACK_DEPTH(2)) dutOvf (
    .clk(clk), .rstN(rstN), .nodeWe(nodeWe), .nodeAddr(nodeAddr), .nodeSplitIn(nodeSplitIn),
    .nodeDimIn(nodeDimIn), .nodeLeafIn(nodeLeafIn), .leafWe(leafWe), .leafAddr(leafAddr),
    .leafBeginIn(leafBeginIn), .leafEndIn(leafEndIn), .start(ovfStart), .queryX(qX),
    .queryY(qY), .queryZ(qZ), .leafReqValid(oValid), .leafReqReady(1'b1),
    .leafBegin(oBeg), .leafEnd(oEnd), .leafDone(ovfLeafDone), .leafWorst('0),
    .busy(oBusy), .searchDone(oDone), .stackErr(oErr));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Behavioural model of R2, R3, R4, R7: ordered list of visited leaves
  task automatic refRun(input longint x, input longint y, input longint z, input longint w);
    longint sD [16];
    int sP [16];
    int sp = 0;
    int p = 1;
    bit fin = 0;
    expN = 0;
    while (!fin) begin
      if (p >= 8 || tLeaf[p] != 0) begin
        expSeq[expN] = p;
        expN++;
        fin = 1;
        while (sp > 0) begin
          sp--;
          if (w > sD[sp]) begin
            p = sP[sp];
            fin = 0;
            break;
          end
        end
      end else begin
        longint c = (tDim[p] == 0) ? x : (tDim[p] == 1) ? y : z;
        longint d = c - tSplit[p];
        sP[sp] = (d > 0) ? 2 * p + 1 : 2 * p;
        sD[sp] = d * d;
        sp++;
        p = (d > 0) ? 2 * p : 2 * p + 1;
      end
    end
  endtask

  task automatic runQuery(input int v, input bit stall);
    int idx = 0;
    int cyc = 0;
    bit fin = 0;
    refRun(VX[v], VY[v], VZ[v], VW[v]);
    @(negedge clk);
    qX = CW'(VX[v]); qY = CW'(VY[v]); qZ = CW'(VZ[v]);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!fin && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (leafReqValid) begin
        // R3 R7: leaf order; R5 R2: payload of that leaf
        check(idx < expN && leafBegin == PW'(expSeq[idx] * 100), "R3/R7 leaf order",
              leafBegin, idx < expN ? expSeq[idx] * 100 : -1);
        check(leafEnd == leafBegin + 7, "R2 leaf end pointer", leafEnd, leafBegin + 7);
        if (stall && idx == 0) begin
          logic [PW-1:0] held = leafBegin;
          repeat (3) begin
            @(negedge clk);
            check(leafReqValid && leafBegin == held, "R5 request held while not ready",
                  leafBegin, held);
          end
        end
        leafReqReady = 1;
        @(negedge clk);
        leafReqReady = 0;
        check(!leafReqValid && busy, "R6 stalled after accept", leafReqValid, 0);
        leafWorst = DW'(VW[v]);
        leafDone = 1;
        @(negedge clk);
        leafDone = 0;
        idx++;
      end
      if (searchDone) begin
        fin = 1;
        check(!busy, "R8 busy drops with done", busy, 0);
        check(idx == expN, "R8 leaf count at done", idx, expN);
        @(negedge clk);
        check(!searchDone, "R8 done is one pulse", searchDone, 0);
      end
    end
    check(fin, "R8 search terminated", fin, 1);
  endtask

  task automatic runOvf(input int x, input int y, input int z);
    int cyc = 0;
    @(negedge clk);
    qX = CW'(x); qY = CW'(y); qZ = CW'(z);
    ovfStart = 1;
    @(negedge clk);
    ovfStart = 0;
    while (!oDone && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (oValid) begin
        @(negedge clk);
        ovfLeafDone = 1;
        @(negedge clk);
        ovfLeafDone = 0;
      end
    end
    check(oDone, "R9 search completes despite overflow", oDone, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // tree: node1 x@0, node2 y@10, node3 flagged leaf, node4 z@-5, node5 x@-20
    tSplit = '{0, 0, 10, 0, -5, -20, 0, 0};
    tDim   = '{0, 0, 1, 0, 2, 0, 0, 0};
    tLeaf  = '{0, 0, 0, 1, 0, 0, 0, 0};
    repeat (3) @(negedge clk);
    // R1: reset values
    check(!busy && !leafReqValid && !searchDone && !stackErr, "R1 reset outputs",
          {busy, leafReqValid, searchDone, stackErr}, 0);
    check(!oBusy && !oErr, "R1 reset outputs small stack", {oBusy, oErr}, 0);
    rstN = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      nodeWe = 1; nodeAddr = TD'(i); nodeSplitIn = CW'(tSplit[i]);
      nodeDimIn = 2'(tDim[i]); nodeLeafIn = tLeaf[i][0];
    end
    @(negedge clk);
    nodeWe = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      leafWe = 1; leafAddr = (TD + 1)'(i);
      leafBeginIn = PW'(i * 100); leafEndIn = PW'(i * 100 + 7);
    end
    @(negedge clk);
    leafWe = 0;
    // vector walk: R3 R4 R7 with worst equal, above, zero and far above plane distances
    for (int v = 0; v < NV; v++) runQuery(v, v == 1);
    check(!stackErr, "R9 no overflow with sufficient stack", stackErr, 0);
    // R9: three pushes into a two-entry stack, then stays set
    runOvf(3, 2, 0);
    check(oErr, "R9 overflow flagged", oErr, 1);
    runOvf(0, 0, 0);
    check(oErr, "R9 overflow sticky", oErr, 1);
    summary();
  end
endmodule